// File: doc/BRIEF.md
# Preemptible Subtractive GCD Core

This core computes the greatest common divisor of two unsigned operands by repeated subtraction, and can be suspended partway through a computation. A surrounding context manager raises the swap line. It waits for the acknowledge, then reads the controller state code and the two working registers from dedicated context ports. Later, possibly after the core has been reset or rebuilt, it writes those values back through the context input ports and releases the swap line. The core then continues and delivers the same result it would have produced if it had never been interrupted.

The controller passes through seven states. Four of them are safe points at which the context is complete: idle, operand capture, reload and compare. The subtract and finish states act on a comparison outcome that is never stored, so a swap request only ever freezes the core in a safe state. If one operand is zero, the other operand is taken as the result, so the subtraction loop always ends.

Top module: `swapGcdCore`

## Requirements
- R1: After reset, stateO is 0, ctxXO, ctxYO and resultO are 0, and doneO and swapAckO are low.
- R2: In state 0 (idle) with swapI low, a high startI loads opAI into X and opBI into Y, and the state becomes 1 (operand capture) on the next cycle.
- R3: If X or Y is zero in state 1, the result is the nonzero one, or 0 if both are zero. Otherwise state 1 goes to state 2 (reload), and state 2 goes to state 3 (compare).
- R4: In state 3 with swapI low, the next state is 5 when X > Y, 4 when X < Y, and 6 when they are equal. State 5 sets X to X - Y and state 4 sets Y to Y - X, and both return to state 3.
- R5: State 6 copies X into resultO, which holds afterwards. doneO goes high for exactly one cycle, in the cycle when the state is back at 0.
- R6: While swapI is high, states 0 to 3 hold, and X and Y do not change. States 4, 5 and 6 complete their own step first.
- R7: swapAckO is high exactly when swapI is high and stateO is 0, 1, 2 or 3.
- R8: ctxXO and ctxYO always show X and Y, and stateO always shows the state code.
- R9: When swapI and ctxLoadI are both high, X and Y take ctxXI and ctxYI. The state takes stateI only if stateI is 0 to 3, and otherwise keeps its code.
- R10: While swapI is low, ctxLoadI, stateI, ctxXI and ctxYI have no effect.
- R11: A context saved at acknowledge and restored after a reset yields the same result as an uninterrupted run.
- R12: While swapI is high, startI is ignored in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Begin a computation from idle |
| opAI | input | W | First operand |
| opBI | input | W | Second operand |
| resultO | output | W | Last computed GCD |
| doneO | output | 1 | One-cycle completion pulse |
| swapI | input | 1 | Suspend request / context load window |
| ctxLoadI | input | 1 | Load context inputs (only while swapI high) |
| swapAckO | output | 1 | Core is parked at a safe state |
| stateO | output | 3 | Current controller state code |
| stateI | input | 3 | State code to restore |
| ctxXO | output | W | Working register X |
| ctxYO | output | W | Working register Y |
| ctxXI | input | W | Value to restore into X |
| ctxYI | input | W | Value to restore into Y |

## Verification
The properties assume that a restored context is one the core itself exported, or one with both registers nonzero when the restored state is reload or compare. A zero register restored into compare would subtract zero forever. They also assume that ctxLoadI is used only as a swap-window strobe. The stimulus restores only contexts it read at acknowledge, or a context parked in idle. The one deliberately bad state code it loads is a non-safe code, which the core must refuse. Zero operands enter only through startI, where the capture state removes them.

// File: rtl/gcdSwapPkg.sv
package gcdSwapPkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_RLD  = 3'd2,
    ST_CMP  = 3'd3,
    ST_NEG  = 3'd4,
    ST_POS  = 3'd5,
    ST_EQ   = 3'd6
  } gcdState_e;

  typedef struct packed {
    logic loadOps;
    logic loadCtx;
    logic fixZero;
    logic subX;
    logic subY;
    logic capture;
  } dpCtrl_t;

  function automatic logic isSafe(input logic [STATE_W-1:0] code);
    return code <= 3'd3;
  endfunction
endpackage

// File: rtl/gcdCtrl.sv
module gcdCtrl
  import gcdSwapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startI,
  input  logic               swapI,
  input  logic               ctxLoadI,
  input  logic [STATE_W-1:0] stateI,
  input  logic               xGtYI,
  input  logic               xEqYI,
  input  logic               anyZeroI,
  output dpCtrl_t            ctrlO,
  output logic [STATE_W-1:0] stateO,
  output logic               swapAckO
);
  gcdState_e stateQ, stateNext;
  logic      loadCtx;

  assign loadCtx = swapI & ctxLoadI;

  always_comb begin
    stateNext = stateQ;
    ctrlO     = '0;
    if (loadCtx) begin
      ctrlO.loadCtx = 1'b1;
      if (isSafe(stateI)) stateNext = gcdState_e'(stateI);
    end else begin
      unique case (stateQ)
        ST_IDLE: if (!swapI && startI) begin
          ctrlO.loadOps = 1'b1;
          stateNext     = ST_INIT;
        end
        ST_INIT: if (!swapI) begin
          if (anyZeroI) begin
            ctrlO.fixZero = 1'b1;
            stateNext     = ST_EQ;
          end else begin
            stateNext = ST_RLD;
          end
        end
        ST_RLD: if (!swapI) stateNext = ST_CMP;
        ST_CMP: if (!swapI) begin
          if (xEqYI)      stateNext = ST_EQ;
          else if (xGtYI) stateNext = ST_POS;
          else            stateNext = ST_NEG;
        end
        ST_POS: begin
          ctrlO.subX = 1'b1;
          stateNext  = ST_CMP;
        end
        ST_NEG: begin
          ctrlO.subY = 1'b1;
          stateNext  = ST_CMP;
        end
        ST_EQ: begin
          ctrlO.capture = 1'b1;
          stateNext     = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  assign stateO   = stateQ;
  assign swapAckO = swapI & isSafe(stateQ);
endmodule

// File: rtl/gcdDatapath.sv
module gcdDatapath
  import gcdSwapPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctrlI,
  input  logic [W-1:0] opAI,
  input  logic [W-1:0] opBI,
  input  logic [W-1:0] ctxXI,
  input  logic [W-1:0] ctxYI,
  output logic [W-1:0] xO,
  output logic [W-1:0] yO,
  output logic [W-1:0] resultO,
  output logic         doneO,
  output logic         xGtYO,
  output logic         xEqYO,
  output logic         anyZeroO
);
  logic [W-1:0] xQ, yQ, resQ;
  logic         doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xQ    <= '0;
      yQ    <= '0;
      resQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctrlI.capture;
      if (ctrlI.capture) resQ <= xQ;
      if (ctrlI.loadCtx) begin
        xQ <= ctxXI;
        yQ <= ctxYI;
      end else if (ctrlI.loadOps) begin
        xQ <= opAI;
        yQ <= opBI;
      end else if (ctrlI.fixZero) begin
        xQ <= xQ | yQ;
      end else if (ctrlI.subX) begin
        xQ <= xQ - yQ;
      end else if (ctrlI.subY) begin
        yQ <= yQ - xQ;
      end
    end
  end

  assign xGtYO    = xQ > yQ;
  assign xEqYO    = xQ == yQ;
  assign anyZeroO = (xQ == '0) || (yQ == '0);
  assign xO       = xQ;
  assign yO       = yQ;
  assign resultO  = resQ;
  assign doneO    = doneQ;
endmodule

// File: rtl/swapGcdCore.sv
module swapGcdCore
  import gcdSwapPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startI,
  input  logic [W-1:0] opAI,
  input  logic [W-1:0] opBI,
  output logic [W-1:0] resultO,
  output logic         doneO,
  input  logic         swapI,
  input  logic         ctxLoadI,
  output logic         swapAckO,
  output logic [2:0]   stateO,
  input  logic [2:0]   stateI,
  output logic [W-1:0] ctxXO,
  output logic [W-1:0] ctxYO,
  input  logic [W-1:0] ctxXI,
  input  logic [W-1:0] ctxYI
);
  dpCtrl_t ctrl;
  logic    xGtY, xEqY, anyZero;

  gcdCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .swapI    (swapI),
    .ctxLoadI (ctxLoadI),
    .stateI   (stateI),
    .xGtYI    (xGtY),
    .xEqYI    (xEqY),
    .anyZeroI (anyZero),
    .ctrlO    (ctrl),
    .stateO   (stateO),
    .swapAckO (swapAckO)
  );

  gcdDatapath #(.W(W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlI    (ctrl),
    .opAI     (opAI),
    .opBI     (opBI),
    .ctxXI    (ctxXI),
    .ctxYI    (ctxYI),
    .xO       (ctxXO),
    .yO       (ctxYO),
    .resultO  (resultO),
    .doneO    (doneO),
    .xGtYO    (xGtY),
    .xEqYO    (xEqY),
    .anyZeroO (anyZero)
  );
endmodule

// File: rtl/gcdSwapChecker.sv
module gcdSwapChecker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         startI,
  input logic         swapI,
  input logic         ctxLoadI,
  input logic [2:0]   stateO,
  input logic [W-1:0] ctxXO,
  input logic [W-1:0] ctxYO,
  input logic         doneO,
  input logic         swapAckO
);
  // R4
  pos_subtract_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateO == 3'd5 && !(swapI && ctxLoadI)) |=> (ctxXO == $past(ctxXO) - $past(ctxYO)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R5
  done_in_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (stateO == 3'd0));

  // R6
  cmp_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swapI && !ctxLoadI && stateO == 3'd3) |=>
      (stateO == 3'd3 && $stable(ctxXO) && $stable(ctxYO)));

  // R7
  ack_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapAckO |-> (swapI && stateO <= 3'd3));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!swapI && !startI && stateO == 3'd0) |=>
      (stateO == 3'd0 && $stable(ctxXO) && $stable(ctxYO)));
endmodule

bind swapGcdCore gcdSwapChecker #(.W(W)) uChk (.*);

// File: tb/tb_swapGcdCore.sv
module tb_swapGcdCore;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic startI = 0, swapI = 0, ctxLoadI = 0;
  logic [W-1:0] opAI = 0, opBI = 0, ctxXI = 0, ctxYI = 0;
  logic [2:0] stateI = 0;
  logic [W-1:0] resultO, ctxXO, ctxYO;
  logic doneO, swapAckO;
  logic [2:0] stateO;

  int checks = 0, failures = 0;
  bit cmpOn = 0;

  swapGcdCore #(.W(W)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  int mState, mX, mY, mRes;
  bit mDone;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mX = 0; mY = 0; mRes = 0; mDone = 0;
    end else begin
      bit d;
      d = 0;
      if (swapI && ctxLoadI) begin
        mX = ctxXI; mY = ctxYI;
        if (stateI <= 3) mState = stateI;
      end else if (mState == 0) begin
        if (!swapI && startI) begin mX = opAI; mY = opBI; mState = 1; end
      end else if (mState == 1) begin
        if (!swapI) begin
          if (mX == 0 || mY == 0) begin mX = mX | mY; mState = 6; end
          else mState = 2;
        end
      end else if (mState == 2) begin
        if (!swapI) mState = 3;
      end else if (mState == 3) begin
        if (!swapI) mState = (mX == mY) ? 6 : (mX > mY) ? 5 : 4;
      end else if (mState == 4) begin
        mY = mY - mX; mState = 3;
      end else if (mState == 5) begin
        mX = mX - mY; mState = 3;
      end else begin
        mRes = mX; d = 1; mState = 0;
      end
      mDone = d;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    chk(stateO == mState, "R6 state", stateO, mState);
    chk(ctxXO == mX, "R8 ctxX", ctxXO, mX);
    chk(ctxYO == mY, "R8 ctxY", ctxYO, mY);
    chk(doneO == mDone, "R5 done", doneO, mDone);
    chk(resultO == mRes, "R3 result", resultO, mRes);
    chk(swapAckO == (swapI && mState <= 3), "R7 ack", swapAckO, swapI && mState <= 3);
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic int euclid(input int a, input int b);
    while (b != 0) begin int t; t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic runGcd(input int a, input int b);
    int n;
    startI = 1; opAI = a[W-1:0]; opBI = b[W-1:0];
    tick();
    startI = 0;
    chk(stateO == 1 && ctxXO == a && ctxYO == b, "R2 capture", stateO, 1);
    n = 0;
    while (!doneO && n < 2000) begin tick(); n++; end
    chk(resultO == euclid(a, b), "R4 gcd", resultO, euclid(a, b));
    tick();
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] sv; logic [W-1:0] sx, sy;
    repeat (2) tick();
    rstN = 1; cmpOn = 1;
    tick();
    // R1
    chk(stateO == 0 && ctxXO == 0 && resultO == 0 && !doneO && !swapAckO, "R1 reset", stateO, 0);

    runGcd(48, 18);
    runGcd(0, 7);   // R3
    runGcd(9, 0);   // R3
    runGcd(0, 0);   // R3
    runGcd(13, 13);
    runGcd(255, 1);
    runGcd(1, 255);
    runGcd(144, 233);

    // R10: context load ignored while swap low
    ctxLoadI = 1; stateI = 3; ctxXI = 99; ctxYI = 77;
    tick();
    ctxLoadI = 0;
    chk(stateO == 0 && ctxXO != 99 && ctxYO != 77, "R10 ignored", ctxXO, 1);

    // R11: suspend mid-run, reset, restore, resume
    startI = 1; opAI = 200; opBI = 75;
    tick();
    startI = 0;
    repeat (4) tick();
    swapI = 1;
    while (!swapAckO) tick();
    sv = stateO; sx = ctxXO; sy = ctxYO;
    repeat (3) tick();
    // R6
    chk(stateO == sv && ctxXO == sx && ctxYO == sy, "R6 frozen", stateO, sv);
    rstN = 0;
    tick();
    rstN = 1;
    tick();
    // R12: start ignored while swap high
    startI = 1; opAI = 5; opBI = 3;
    tick();
    startI = 0;
    chk(stateO == 0 && ctxXO == 0, "R12 start ignored", stateO, 0);
    // R9: non-safe code refused, registers still loaded
    ctxLoadI = 1; stateI = 5; ctxXI = 3; ctxYI = 4;
    tick();
    chk(stateO == 0 && ctxXO == 3 && ctxYO == 4, "R9 bad code", stateO, 0);
    stateI = sv; ctxXI = sx; ctxYI = sy;
    tick();
    ctxLoadI = 0;
    chk(stateO == sv && ctxXO == sx && ctxYO == sy, "R9 restore", stateO, sv);
    swapI = 0;
    begin
      int n; n = 0;
      while (!doneO && n < 2000) begin tick(); n++; end
    end
    chk(resultO == 25, "R11 resumed gcd", resultO, 25);
    tick();

    runGcd(100, 60);
    cmpOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule